// File: doc/BRIEF.md
# High-Voltage Supply Rail Sequencer

This block orders the connection and disconnection of the three supply rails that feed a bank of high-voltage amplifiers. On a power-up request it closes the rail switches one at a time: the 300 V positive rail first, then the -5.5 V negative rail, then the 6.5 V logic rail. A programmable settling interval separates each step. When all three rails are closed, the block asserts a latch-enable that freezes the external switch latch. It then releases its switch control lines to zero so that other logic can share them, and it raises a powered-on flag for the supervising state machine.

A host power-down request or the emergency shutdown input (asynchronous, synchronised on entry) removes the rails in exactly the reverse order. Before the latch opens, the control lines are reloaded with the rail states the latch is holding, so opening the latch does not disturb any rail. A power-down request that arrives part-way through power-up aborts it and removes only the rails that are already closed, highest first. An optional good flag from the supplies can hold off the final power-up step until the supplies report healthy.

Top module: `hv_rail_seq`

## Requirements
- R1: After reset, all switch control lines (`sw_ctrl`, bit 0 = 300 V rail, bit 1 = -5.5 V rail, bit 2 = 6.5 V rail) are 0, `latch_en` is 0, `pwr_off` is 1, and `busy` and `pwr_on` are 0.
- R2: A power-up request sampled while off sets `sw_ctrl` to 001 on that clock edge. The lines become 011 after SETTLE_CYC cycles and 111 after a further SETTLE_CYC cycles. No other pattern occurs on the way up.
- R3: SETTLE_CYC cycles after `sw_ctrl` reaches 111, `latch_en` rises and `pwr_on` is set while `sw_ctrl` is still 111. On the next edge `sw_ctrl` falls to 000.
- R4: While powered on, `sw_ctrl` stays 000, the rails held by the latch never change, and a further power-up request has no effect.
- R5: A power-down request while on reloads `sw_ctrl` to 111 with `latch_en` still high. `latch_en` drops one cycle later. One cycle after that, the lines become 011, then 001 and 000 at SETTLE_CYC spacing. `pwr_off` follows SETTLE_CYC cycles after 000.
- R6: A power-down request during power-up aborts it. The highest closed rail opens on the next edge, and the remaining closed rails open in reverse order at SETTLE_CYC spacing. No rail closes during any power-down.
- R7: The emergency shutdown input passes through two synchroniser flops and then acts like a power-down request. While it is active (including together with a power-up request) no power-up starts.
- R8: A power-down request while off, and a power-up request during power-down, are both ignored.
- R9: With GOOD_EN set, the step that latches the rails waits until `rails_ok` is high. While `rails_ok` is low the block stays busy with all three lines closed.
- R10: Exactly one of `busy`, `pwr_on` and `pwr_off` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Power-up request from the supervisor |
| down_req | input | 1 | Host power-down request |
| estop_async | input | 1 | Emergency shutdown button, asynchronous |
| rails_ok | input | 1 | Supplies healthy flag (used when GOOD_EN=1) |
| sw_ctrl | output | N_RAIL | Shared rail switch control lines, thermometer order |
| latch_en | output | 1 | Holds the external switch latch closed |
| busy | output | 1 | Sequence in progress |
| pwr_on | output | 1 | All rails connected and latched |
| pwr_off | output | 1 | All rails disconnected |

## Verification
The in-RTL assertions check the per-cycle properties on every cycle: the control lines only ever carry a thermometer pattern, the latch rises and falls only with every line closed, the lines stay released while powered on, no rail closes during power-down, and the three status flags stay mutually exclusive. Several properties involve counts and sequences that only the bench scenarios can show. These are the exact settling spacing of each step, the reverse order after an abort at different points, the two-cycle synchroniser latency of the shutdown input, the hold-off by the good flag, and the ignored requests. The bench shows them by modelling the external latch and watching the rail states that result.

// File: rtl/hvs_pkg.sv
package hvs_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_UP      = 3'd1,
    ST_ON      = 3'd2,
    ST_RELOAD  = 3'd3,
    ST_UNLATCH = 3'd4,
    ST_DN      = 3'd5
  } seq_state_t;
endpackage

// File: rtl/hvs_sync2.sv
module hvs_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;

  // R7
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> $past(meta_q));
endmodule

// File: rtl/hvs_settle_timer.sv
module hvs_settle_timer #(
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic done
);
  localparam int unsigned CW   = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == LAST);
  assign cnt_en = clr || !done;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (!done) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R2
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done);
endmodule

// File: rtl/hvs_seq_fsm.sv
module hvs_seq_fsm
  import hvs_pkg::*;
#(
  parameter int unsigned N_RAIL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req,
  input  logic              stop_req,
  input  logic              good_ok,
  input  logic              t_done,
  output logic              t_clr,
  output logic [N_RAIL-1:0] sw_ctrl,
  output logic              latch_en,
  output logic              busy,
  output logic              pwr_on,
  output logic              pwr_off
);
  localparam logic [N_RAIL-1:0] ALL_ON  = '1;
  localparam logic [N_RAIL-1:0] ALL_OFF = '0;

  seq_state_t        st_q, st_d;
  logic [N_RAIL-1:0] ctrl_q, ctrl_d;
  logic              latch_q, latch_d;

  function automatic logic [N_RAIL-1:0] step_up(input logic [N_RAIL-1:0] v);
    step_up = (v << 1) | {{(N_RAIL-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [N_RAIL-1:0] step_dn(input logic [N_RAIL-1:0] v);
    step_dn = v >> 1;
  endfunction

  always_comb begin
    st_d    = st_q;
    ctrl_d  = ctrl_q;
    latch_d = latch_q;
    t_clr   = 1'b0;
    case (st_q)
      ST_OFF: begin
        ctrl_d  = ALL_OFF;
        latch_d = 1'b0;
        t_clr   = 1'b1;
        if (up_req && !stop_req) begin
          st_d   = ST_UP;
          ctrl_d = step_up(ALL_OFF);
        end
      end
      ST_UP: begin
        if (stop_req) begin
          st_d   = ST_DN;
          ctrl_d = step_dn(ctrl_q);
          t_clr  = 1'b1;
        end else if (t_done && (ctrl_q == ALL_ON)) begin
          if (good_ok) begin
            st_d    = ST_ON;
            latch_d = 1'b1;
          end
        end else if (t_done) begin
          ctrl_d = step_up(ctrl_q);
          t_clr  = 1'b1;
        end
      end
      ST_ON: begin
        if (stop_req) begin
          st_d   = ST_RELOAD;
          ctrl_d = ALL_ON;
        end else begin
          ctrl_d = ALL_OFF;
        end
      end
      ST_RELOAD: begin
        st_d    = ST_UNLATCH;
        latch_d = 1'b0;
      end
      ST_UNLATCH: begin
        st_d   = ST_DN;
        ctrl_d = step_dn(ctrl_q);
        t_clr  = 1'b1;
      end
      ST_DN: begin
        if (t_done) begin
          t_clr = 1'b1;
          if (ctrl_q == ALL_OFF) begin
            st_d = ST_OFF;
          end else begin
            ctrl_d = step_dn(ctrl_q);
          end
        end
      end
      default: begin
        st_d    = ST_OFF;
        ctrl_d  = ALL_OFF;
        latch_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      ctrl_q  <= '0;
      latch_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ctrl_q  <= ctrl_d;
      latch_q <= latch_d;
    end
  end

  assign sw_ctrl  = ctrl_q;
  assign latch_en = latch_q;
  assign pwr_on   = (st_q == ST_ON);
  assign pwr_off  = (st_q == ST_OFF);
  assign busy     = !pwr_on && !pwr_off;

  // R2
  thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q & (ctrl_q + 1'b1)) == '0));
  // R3
  latch_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> (ctrl_q == ALL_ON));
  // R4
  on_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && $past(pwr_on)) |-> (ctrl_q == ALL_OFF || $past(ctrl_q) == ALL_OFF));
  // R5
  latch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_q) |-> (ctrl_q == ALL_ON && $past(ctrl_q) == ALL_ON));
  // R6
  no_close_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DN || st_q == ST_UNLATCH) |=> ((ctrl_q & ~$past(ctrl_q)) == '0));
  // R10
  status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({busy, pwr_on, pwr_off}) == 1);
endmodule

// File: rtl/hv_rail_seq.sv
module hv_rail_seq #(
  parameter int unsigned N_RAIL     = 3,
  parameter int unsigned SETTLE_CYC = 2_000_000,
  parameter bit          GOOD_EN    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req,
  input  logic              down_req,
  input  logic              estop_async,
  input  logic              rails_ok,
  output logic [N_RAIL-1:0] sw_ctrl,
  output logic              latch_en,
  output logic              busy,
  output logic              pwr_on,
  output logic              pwr_off
);
  logic estop_s;
  logic stop_req;
  logic good_ok;
  logic t_clr;
  logic t_done;

  hvs_sync2 u_estop_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (estop_async),
    .q_sync  (estop_s)
  );

  assign stop_req = estop_s || down_req;

  generate
    if (GOOD_EN) begin : g_good
      assign good_ok = rails_ok;
    end else begin : g_nogood
      assign good_ok = 1'b1;
    end
  endgenerate

  hvs_settle_timer #(
    .SETTLE_CYC (SETTLE_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (t_clr),
    .done  (t_done)
  );

  hvs_seq_fsm #(
    .N_RAIL (N_RAIL)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_req   (up_req),
    .stop_req (stop_req),
    .good_ok  (good_ok),
    .t_done   (t_done),
    .t_clr    (t_clr),
    .sw_ctrl  (sw_ctrl),
    .latch_en (latch_en),
    .busy     (busy),
    .pwr_on   (pwr_on),
    .pwr_off  (pwr_off)
  );
endmodule

// File: tb/hv_rail_seq_tb.sv
module hv_rail_seq_tb;
  localparam int S = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up_req = 1'b0;
  logic       down_req = 1'b0;
  logic       estop_async = 1'b0;
  logic       rails_ok = 1'b1;
  logic [2:0] sw_ctrl;
  logic       latch_en, busy, pwr_on, pwr_off;

  always #2.5 clk = ~clk;

  hv_rail_seq #(.N_RAIL(3), .SETTLE_CYC(S), .GOOD_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
    .estop_async(estop_async), .rails_ok(rails_ok), .sw_ctrl(sw_ctrl),
    .latch_en(latch_en), .busy(busy), .pwr_on(pwr_on), .pwr_off(pwr_off));

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  // model of the external switch latch: transparent while latch_en is low
  logic [2:0] held = 3'b000;
  always @(negedge clk) if (!latch_en) held <= sw_ctrl;
  wire [2:0] eff = latch_en ? held : sw_ctrl;

  // monitor of the rail states seen by the amplifiers
  logic [2:0] prev_eff = 3'b000;
  int since = 1000;
  int last_dir = 0;
  int order_bad = 0, dwell_bad = 0, glitch_bad = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (eff != prev_eff) begin
        for (int i = 0; i < 3; i++) begin
          if (eff[i] && !prev_eff[i]) begin
            for (int j = 0; j < i; j++) if (!eff[j]) order_bad++;
            if (last_dir == 1 && since < S) dwell_bad++;
            last_dir = 1;
          end
          if (!eff[i] && prev_eff[i]) begin
            for (int j = i + 1; j < 3; j++) if (eff[j]) order_bad++;
            if (last_dir == -1 && since < S) dwell_bad++;
            last_dir = -1;
          end
        end
        if (pwr_on) glitch_bad++;
        since = 1;
      end else begin
        since++;
      end
      prev_eff = eff;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 2000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic pulse_up();
    up_req = 1'b1; @(negedge clk); up_req = 1'b0;
  endtask

  task automatic pulse_dn();
    down_req = 1'b1; @(negedge clk); down_req = 1'b0;
  endtask

  // {cmd[3:0], arg[5:0], exp_on, exp_off}
  // cmd: 0 up, 1 down, 2 estop, 3 up then abort after arg cycles
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {4'd0, 6'd0,  1'b1, 1'b0},
    {4'd0, 6'd0,  1'b1, 1'b0},
    {4'd1, 6'd0,  1'b0, 1'b1},
    {4'd1, 6'd0,  1'b0, 1'b1},
    {4'd0, 6'd0,  1'b1, 1'b0},
    {4'd2, 6'd0,  1'b0, 1'b1},
    {4'd3, 6'd2,  1'b0, 1'b1},
    {4'd3, 6'd8,  1'b0, 1'b1},
    {4'd3, 6'd14, 1'b0, 1'b1},
    {4'd0, 6'd0,  1'b1, 1'b0}
  };

  initial begin
    cyc(3);
    // R1 reset state
    chk(sw_ctrl == 3'b000 && !latch_en, "R1", int'({latch_en, sw_ctrl}), 0);
    chk(pwr_off && !busy && !pwr_on, "R1", int'({busy, pwr_on, pwr_off}), 1);
    rst_n = 1'b1;
    cyc(2);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] cmd;
      logic [5:0] arg;
      cmd = VEC[v][11:8];
      arg = VEC[v][7:2];
      case (cmd)
        4'd0: pulse_up();
        4'd1: pulse_dn();
        4'd2: begin estop_async = 1'b1; cyc(3); estop_async = 1'b0; end
        default: begin pulse_up(); cyc(int'(arg)); pulse_dn(); end
      endcase
      cyc(1);
      wait_idle();
      cyc(2);
      // R2 R5 R6 R8 end state of each scenario
      chk(pwr_on == VEC[v][1] && pwr_off == VEC[v][0], "R8",
          int'({pwr_on, pwr_off}), int'(VEC[v][1:0]));
      chk(eff == (VEC[v][1] ? 3'b111 : 3'b000), "R6", int'(eff),
          VEC[v][1] ? 7 : 0);
    end
    // leave off
    pulse_dn(); cyc(1); wait_idle();

    // R2 R3 exact power-up timing
    up_req = 1'b1; @(negedge clk); up_req = 1'b0;
    chk(sw_ctrl == 3'b001, "R2", int'(sw_ctrl), 1);
    cyc(S - 1);
    chk(sw_ctrl == 3'b001, "R2", int'(sw_ctrl), 1);
    cyc(1);
    chk(sw_ctrl == 3'b011, "R2", int'(sw_ctrl), 3);
    cyc(S);
    chk(sw_ctrl == 3'b111 && !latch_en, "R2", int'({latch_en, sw_ctrl}), 7);
    cyc(S);
    chk(latch_en && pwr_on && sw_ctrl == 3'b111, "R3", int'({pwr_on, latch_en, sw_ctrl}), 31);
    cyc(1);
    chk(sw_ctrl == 3'b000 && latch_en && eff == 3'b111, "R3", int'(sw_ctrl), 0);
    // R4 up request while on has no effect
    pulse_up(); cyc(3);
    chk(pwr_on && sw_ctrl == 3'b000 && eff == 3'b111, "R4", int'({pwr_on, eff}), 15);

    // R5 exact power-down timing
    pulse_dn();
    chk(sw_ctrl == 3'b111 && latch_en && busy, "R5", int'({latch_en, sw_ctrl}), 15);
    cyc(1);
    chk(sw_ctrl == 3'b111 && !latch_en, "R5", int'({latch_en, sw_ctrl}), 7);
    cyc(1);
    chk(sw_ctrl == 3'b011, "R5", int'(sw_ctrl), 3);
    // R8 up request during power-down ignored
    pulse_up();
    cyc(S - 1);
    chk(sw_ctrl == 3'b001, "R8", int'(sw_ctrl), 1);
    cyc(S);
    chk(sw_ctrl == 3'b000 && busy, "R5", int'({busy, sw_ctrl}), 8);
    cyc(S);
    chk(pwr_off, "R5", int'(pwr_off), 1);
    // R8 down request while off ignored
    pulse_dn(); cyc(2);
    chk(pwr_off && sw_ctrl == 3'b000, "R8", int'({pwr_off, sw_ctrl}), 8);

    // R7 estop latency: two sync flops then reload
    pulse_up(); cyc(1); wait_idle(); cyc(1);
    estop_async = 1'b1;
    cyc(2);
    chk(pwr_on, "R7", int'(pwr_on), 1);
    cyc(1);
    chk(!pwr_on && busy && sw_ctrl == 3'b111, "R7", int'({pwr_on, busy}), 1);
    cyc(1); wait_idle(); cyc(1);
    // R7 estop held: up request does not start
    up_req = 1'b1; cyc(3); up_req = 1'b0;
    chk(pwr_off && sw_ctrl == 3'b000, "R7", int'({pwr_off, sw_ctrl}), 8);
    estop_async = 1'b0; cyc(3);

    // R9 good flag holds off latching
    rails_ok = 1'b0;
    pulse_up();
    cyc(3 * S + 5);
    chk(busy && sw_ctrl == 3'b111 && !latch_en, "R9", int'({busy, latch_en, sw_ctrl}), 23);
    rails_ok = 1'b1;
    cyc(2);
    chk(pwr_on && latch_en, "R9", int'({pwr_on, latch_en}), 3);
    // R10 status exclusivity at a few points
    chk(int'(busy) + int'(pwr_on) + int'(pwr_off) == 1, "R10",
        int'(busy) + int'(pwr_on) + int'(pwr_off), 1);
    pulse_dn(); cyc(1); wait_idle(); cyc(2);

    // monitor results
    chk(order_bad == 0, "R6", order_bad, 0);
    chk(dwell_bad == 0, "R2", dwell_bad, 0);
    chk(glitch_bad == 0, "R4", glitch_bad, 0);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(100000);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule